// File: doc/BRIEF.md
# Two-Dimensional 64-Point FFT/IFFT Engine

This block transforms a frame of 64 complex fixed-point samples into its 64-point discrete Fourier transform, forward or inverse. The transform is split into an 8-by-8 grid. A first pass runs eight 8-point transforms over groups of samples taken at stride 8. Each intermediate value off the grid edges is then rotated by a 64th-root-of-unity twiddle. A second pass runs eight more 8-point transforms over the rotated values. The 8-point core has no general multiplier. Its only non-trivial constant, one over root two, is applied with shifts and adds. A single shared complex multiplier serves the inter-pass rotations.

A frame is written serially, one sample per cycle, while the engine is idle. Pulsing `start` runs the transform. `done` then pulses for one cycle, and the 64 results stream out in natural frequency order with `out_valid`. Inverse mode conjugates every twiddle and leaves the 1/64 scaling to downstream logic, which suits the transmit side of an OFDM baseband.

Top module: `fft64_2d`

## Requirements
- R1: With `inverse`=0 at the accepted `start`, output sample k equals the sum over n of x[n]·e^(−j2πnk/64), within 32 LSB on each of the real and imaginary parts. x[n] is the n-th sample written with `in_valid` since reset or since the previous accepted `start`.
- R2: With `inverse`=1 at the accepted `start`, output sample k equals the unscaled sum over n of x[n]·e^(+j2πnk/64), with the same tolerance.
- R3: The direction is taken from `inverse` in the cycle `start` is accepted. Changing `inverse` later in the frame has no effect on that frame.
- R4: `done` is high for exactly one cycle. That cycle follows the 66th rising edge, counting the edge that accepts `start` as the first.
- R5: `out_valid` is high for exactly 64 consecutive cycles, beginning in the cycle right after `done`. The k-th valid beat (k from 0) carries output sample k.
- R6: `busy` is high from the cycle after `start` is accepted until the last output beat. `start` is ignored while `busy` is high.
- R7: `in_valid` is ignored while `busy` is high. It neither alters the frame being transformed nor advances the load position.
- R8: After reset `busy`, `done` and `out_valid` are low.
- R9: Outputs are `IN_W`+8 bits wide, so full-scale inputs never overflow. A DC frame of value v gives 64·v in sample 0 and zero elsewhere.
- R10: The inter-pass rotation spends one cycle on each of the 49 grid positions whose row and column are both non-zero. Positions in row 0 or column 0 are never sent through the multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Writes one input sample at the next load position while idle |
| in_re | input | IN_W | Real part of the input sample, two's complement |
| in_im | input | IN_W | Imaginary part of the input sample, two's complement |
| inverse | input | 1 | 1 selects the inverse transform, 0 the forward transform |
| start | input | 1 | Begins a transform when idle |
| busy | output | 1 | Transform or output stream in progress |
| done | output | 1 | One-cycle pulse before the output stream |
| out_valid | output | 1 | Output sample valid |
| out_re | output | IN_W+8 | Real part of the output sample |
| out_im | output | IN_W+8 | Imaginary part of the output sample |

## Verification
The assertions check the handshake every cycle. They cover the single-cycle `done`, an output run of exactly 64 beats right after it, `busy` rising only on a `start`, and the reset values. They also check that the rotation stage never visits a row-0 or column-0 position and that no two buffer-writing phases overlap. The numerical results of both directions, the direction being fixed at `start`, the 66-cycle latency, and the immunity to `start` and `in_valid` while busy can only be shown by the bench. It compares full frames (impulses, full-scale DC, alternating full-scale, random data) against a floating-point DFT.

// File: rtl/fft64_pkg.sv
package fft64_pkg;
  localparam int PTS       = 64;
  localparam int RAD       = 8;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ROWS, PH_TWID, PH_COLS, PH_DONE, PH_DRAIN
  } phase_t;

  // cos(2*pi*k/64) in Q14 for the first quadrant, k = 0..16
  function automatic logic signed [COEF_W-1:0] quarter_cos(input int k);
    case (k)
      0:  return 16'sd16384;
      1:  return 16'sd16305;
      2:  return 16'sd16069;
      3:  return 16'sd15679;
      4:  return 16'sd15137;
      5:  return 16'sd14449;
      6:  return 16'sd13623;
      7:  return 16'sd12665;
      8:  return 16'sd11585;
      9:  return 16'sd10394;
      10: return 16'sd9102;
      11: return 16'sd7723;
      12: return 16'sd6270;
      13: return 16'sd4756;
      14: return 16'sd3196;
      15: return 16'sd1606;
      default: return 16'sd0;
    endcase
  endfunction

  // cos(2*pi*n/64) in Q14 from quadrant symmetry
  function automatic logic signed [COEF_W-1:0] cos64(input int n);
    int m;
    m = n % PTS;
    if (m < 0) m = m + PTS;
    if (m <= 16)      return quarter_cos(m);
    else if (m <= 32) return -quarter_cos(32 - m);
    else if (m <= 48) return -quarter_cos(m - 32);
    else              return quarter_cos(PTS - m);
  endfunction

  // sin(2*pi*n/64) = cos(2*pi*(n-16)/64)
  function automatic logic signed [COEF_W-1:0] sin64(input int n);
    return cos64(n + 48);
  endfunction

  function automatic logic [2:0] rev3(input logic [2:0] v);
    return {v[0], v[1], v[2]};
  endfunction
endpackage

// File: rtl/fft8_core.sv
// Combinational multiplierless 8-point DFT, decimation in frequency.
module fft8_core #(
  parameter int W = 20
) (
  input  logic                inv,
  input  logic signed [W-1:0] a_re [8],
  input  logic signed [W-1:0] a_im [8],
  output logic signed [W-1:0] y_re [8],
  output logic signed [W-1:0] y_im [8]
);
  import fft64_pkg::*;

  // v * 181/256 (~1/sqrt2) with shifts and adds, rounded
  function automatic logic signed [W-1:0] half_root(input logic signed [W-1:0] v);
    logic signed [W+8:0] e;
    logic signed [W+8:0] acc;
    e   = (W+9)'(v);
    acc = (e <<< 7) + (e <<< 5) + (e <<< 4) + (e <<< 2) + e + (W+9)'(128);
    return W'(acc >>> 8);
  endfunction

  // multiply by W8^k (forward) or its conjugate (inverse), k = 0..3
  function automatic logic [2*W-1:0] rot8(input logic signed [W-1:0] re,
                                          input logic signed [W-1:0] im,
                                          input logic [1:0] k, input logic iv);
    logic signed [W-1:0] pr, pi;
    case ({iv, k})
      3'b001:  begin pr = half_root(re + im);  pi = half_root(im - re);  end
      3'b101:  begin pr = half_root(re - im);  pi = half_root(re + im);  end
      3'b010:  begin pr = im;                  pi = -re;                 end
      3'b110:  begin pr = -im;                 pi = re;                  end
      3'b011:  begin pr = half_root(im - re);  pi = half_root(-re - im); end
      3'b111:  begin pr = half_root(-re - im); pi = half_root(re - im);  end
      default: begin pr = re;                  pi = im;                  end
    endcase
    return {pr, pi};
  endfunction

  logic signed [W-1:0] u_re [8], u_im [8];
  logic signed [W-1:0] v_re [8], v_im [8];
  logic signed [W-1:0] w_re [8], w_im [8];

  always_comb begin
    for (int n = 0; n < 4; n++) begin
      u_re[n] = a_re[n] + a_re[n+4];
      u_im[n] = a_im[n] + a_im[n+4];
      {u_re[n+4], u_im[n+4]} = rot8(a_re[n] - a_re[n+4], a_im[n] - a_im[n+4],
                                    2'(n), inv);
    end
    for (int h = 0; h < 8; h += 4) begin
      for (int n = 0; n < 2; n++) begin
        v_re[h+n] = u_re[h+n] + u_re[h+n+2];
        v_im[h+n] = u_im[h+n] + u_im[h+n+2];
        {v_re[h+n+2], v_im[h+n+2]} = rot8(u_re[h+n] - u_re[h+n+2],
                                          u_im[h+n] - u_im[h+n+2], 2'(2*n), inv);
      end
    end
    for (int i = 0; i < 4; i++) begin
      w_re[2*i]   = v_re[2*i] + v_re[2*i+1];
      w_im[2*i]   = v_im[2*i] + v_im[2*i+1];
      w_re[2*i+1] = v_re[2*i] - v_re[2*i+1];
      w_im[2*i+1] = v_im[2*i] - v_im[2*i+1];
    end
    for (int i = 0; i < 8; i++) begin
      y_re[rev3(3'(i))] = w_re[i];
      y_im[rev3(3'(i))] = w_im[i];
    end
  end
endmodule

// File: rtl/twiddle_mul.sv
// Complex rotation by W64^expo (conjugated in inverse mode), Q14 constants.
module twiddle_mul #(
  parameter int W = 20
) (
  input  logic                inv,
  input  logic [5:0]          expo,
  input  logic signed [W-1:0] d_re,
  input  logic signed [W-1:0] d_im,
  output logic signed [W-1:0] p_re,
  output logic signed [W-1:0] p_im
);
  import fft64_pkg::*;

  localparam int PW = W + COEF_W + 1;

  logic signed [COEF_W-1:0] c_k, s_k, d_k;
  logic signed [PW-1:0]     ae, be, ce, de, pr, pi;

  always_comb begin
    c_k = cos64(int'(expo));
    s_k = sin64(int'(expo));
    d_k = inv ? s_k : -s_k;
    ae  = PW'(d_re);
    be  = PW'(d_im);
    ce  = PW'(c_k);
    de  = PW'(d_k);
    pr  = ae * ce - be * de + PW'(1 << (COEF_FRAC - 1));
    pi  = ae * de + be * ce + PW'(1 << (COEF_FRAC - 1));
    p_re = W'(pr >>> COEF_FRAC);
    p_im = W'(pi >>> COEF_FRAC);
  end
endmodule

// File: rtl/fft64_seq.sv
// Phase sequencer: row pass, 49-step rotation, column pass, done, drain.
module fft64_seq (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output fft64_pkg::phase_t    phase,
  output logic [2:0]           grp,
  output logic [2:0]           tw_l,
  output logic [2:0]           tw_s,
  output logic [5:0]           drain_cnt
);
  import fft64_pkg::*;

  localparam int GW = $clog2(RAD);
  localparam int AW = $clog2(PTS);
  localparam logic [GW-1:0] LAST_G = GW'(RAD - 1);
  localparam logic [AW-1:0] LAST_A = AW'(PTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      grp       <= '0;
      tw_l      <= GW'(1);
      tw_s      <= GW'(1);
      drain_cnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_ROWS;
          grp   <= '0;
        end
        PH_ROWS: begin
          grp <= grp + 1'b1;
          if (grp == LAST_G) begin
            phase <= PH_TWID;
            tw_l  <= GW'(1);
            tw_s  <= GW'(1);
          end
        end
        PH_TWID: begin
          if (tw_l == LAST_G) begin
            tw_l <= GW'(1);
            if (tw_s == LAST_G) begin
              phase <= PH_COLS;
              grp   <= '0;
            end else begin
              tw_s <= tw_s + 1'b1;
            end
          end else begin
            tw_l <= tw_l + 1'b1;
          end
        end
        PH_COLS: begin
          grp <= grp + 1'b1;
          if (grp == LAST_G) phase <= PH_DONE;
        end
        PH_DONE: begin
          phase     <= PH_DRAIN;
          drain_cnt <= '0;
        end
        PH_DRAIN: begin
          drain_cnt <= drain_cnt + 1'b1;
          if (drain_cnt == LAST_A) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fft64_2d.sv
module fft64_2d #(
  parameter int IN_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_re,
  input  logic signed [IN_W-1:0]   in_im,
  input  logic                     inverse,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     out_valid,
  output logic signed [IN_W+7:0]   out_re,
  output logic signed [IN_W+7:0]   out_im
);
  import fft64_pkg::*;

  localparam int DW = IN_W + 8;
  localparam int GW = $clog2(RAD);
  localparam int AW = $clog2(PTS);

  phase_t          phase;
  logic [GW-1:0]   grp, tw_l, tw_s;
  logic [AW-1:0]   drain_cnt;
  logic [AW-1:0]   wptr;
  logic            mode_q;

  logic signed [DW-1:0] bufr [PTS];
  logic signed [DW-1:0] bufi [PTS];

  // named events for the checker
  logic start_fire, load_fire, rows_wr, cols_wr, tw_fire;

  assign busy       = (phase != PH_IDLE);
  assign done       = (phase == PH_DONE);
  assign out_valid  = (phase == PH_DRAIN);
  assign start_fire = start && !busy;
  assign load_fire  = in_valid && !busy;
  assign rows_wr    = (phase == PH_ROWS);
  assign cols_wr    = (phase == PH_COLS);
  assign tw_fire    = (phase == PH_TWID);

  fft64_seq i_seq (
    .clk(clk), .rst_n(rst_n), .start(start_fire), .phase(phase),
    .grp(grp), .tw_l(tw_l), .tw_s(tw_s), .drain_cnt(drain_cnt)
  );

  // core operand addresses: row pass reads stride 8, column pass reads contiguous 8
  logic [AW-1:0]        rd_addr [RAD];
  logic signed [DW-1:0] core_ir [RAD], core_ii [RAD];
  logic signed [DW-1:0] core_or [RAD], core_oi [RAD];

  for (genvar k = 0; k < RAD; k++) begin : g_lane
    assign rd_addr[k] = rows_wr ? {GW'(k), grp} : {grp, GW'(k)};
    assign core_ir[k] = bufr[rd_addr[k]];
    assign core_ii[k] = bufi[rd_addr[k]];
  end

  fft8_core #(.W(DW)) i_core (
    .inv(mode_q), .a_re(core_ir), .a_im(core_ii), .y_re(core_or), .y_im(core_oi)
  );

  logic [AW-1:0]        tw_addr;
  logic [5:0]           tw_expo;
  logic signed [DW-1:0] mul_re, mul_im;

  assign tw_addr = {tw_s, tw_l};
  assign tw_expo = 6'(tw_l) * 6'(tw_s);

  twiddle_mul #(.W(DW)) i_twid (
    .inv(mode_q), .expo(tw_expo), .d_re(bufr[tw_addr]), .d_im(bufi[tw_addr]),
    .p_re(mul_re), .p_im(mul_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      mode_q <= 1'b0;
    end else if (start_fire) begin
      wptr   <= '0;
      mode_q <= inverse;
    end else if (load_fire) begin
      wptr   <= wptr + 1'b1;
    end
  end

  // in-place buffer: every pass writes back to the addresses it read
  always_ff @(posedge clk) begin
    if (load_fire) begin
      bufr[wptr] <= DW'(in_re);
      bufi[wptr] <= DW'(in_im);
    end
    if (rows_wr || cols_wr) begin
      for (int k = 0; k < RAD; k++) begin
        bufr[rd_addr[k]] <= core_or[k];
        bufi[rd_addr[k]] <= core_oi[k];
      end
    end
    if (tw_fire) begin
      bufr[tw_addr] <= mul_re;
      bufi[tw_addr] <= mul_im;
    end
  end

  // output k = s + 8t lives at address 8s + t
  logic [AW-1:0] out_addr;
  assign out_addr = {drain_cnt[GW-1:0], drain_cnt[AW-1:GW]};
  assign out_re   = out_valid ? bufr[out_addr] : '0;
  assign out_im   = out_valid ? bufi[out_addr] : '0;
endmodule

// File: rtl/fft64_chk.sv
module fft64_chk #(
  parameter int GW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          out_valid,
  input logic          rows_wr,
  input logic          cols_wr,
  input logic          tw_fire,
  input logic [GW-1:0] tw_l,
  input logic [GW-1:0] tw_s
);
  logic [7:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         beats <= '0;
    else if (out_valid) beats <= beats + 1'b1;
    else                beats <= '0;
  end

  // R8
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (!busy && !done && !out_valid));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R5
  drain_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> out_valid);

  // R5
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> beats < 8'd64);

  // R5
  drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(out_valid) |-> beats == 8'd64);

  // R6
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));

  // R10
  twiddle_nontrivial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_fire |-> (tw_l != '0 && tw_s != '0));

  // R10
  phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rows_wr, tw_fire, cols_wr, out_valid}));
endmodule

bind fft64_2d fft64_chk #(.GW(3)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .out_valid(out_valid), .rows_wr(rows_wr), .cols_wr(cols_wr),
  .tw_fire(tw_fire), .tw_l(tw_l), .tw_s(tw_s)
);

// File: tb/test_fft64_2d.sv
`timescale 1ns/1ps
module test_fft64_2d;
  localparam int IN_W = 12;
  localparam int DW   = IN_W + 8;
  localparam real TOL = 32.0;
  localparam real PI2 = 6.283185307179586;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, inverse = 1'b0, start = 1'b0;
  logic signed [IN_W-1:0] in_re = '0, in_im = '0;
  logic busy, done, out_valid;
  logic signed [DW-1:0] out_re, out_im;

  int errors = 0, checks = 0;
  bit finished = 0;
  int  xr [64], xi [64];
  real rr [64], ri [64];

  always #4 clk = ~clk;

  fft64_2d #(.IN_W(IN_W)) i_fft64_2d (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .inverse(inverse), .start(start), .busy(busy), .done(done),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic calc_ref(input bit inv);
    for (int k = 0; k < 64; k++) begin
      real sr, si, ang;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < 64; n++) begin
        ang = PI2 * real'((n * k) % 64) / 64.0;
        if (!inv) ang = -ang;
        sr += real'(xr[n]) * $cos(ang) - real'(xi[n]) * $sin(ang);
        si += real'(xr[n]) * $sin(ang) + real'(xi[n]) * $cos(ang);
      end
      rr[k] = sr; ri[k] = si;
    end
  endtask

  task automatic load_frame();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_re = IN_W'(xr[i]); in_im = IN_W'(xi[i]);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic bit near(input int a, input real e);
    real d;
    d = real'(a) - e;
    return (d <= TOL) && (d >= -TOL);
  endfunction

  // flip: change inverse after start; disturb: drive start and in_valid while busy
  task automatic run_frame(input bit inv, input bit flip, input bit disturb, input string tag);
    int cyc;
    calc_ref(inv);
    @(negedge clk);
    start = 1'b1; inverse = inv;
    @(negedge clk);
    start = disturb; cyc = 1;
    if (flip) inverse = ~inv;
    check(busy == 1'b1, "R6", "busy after start", int'(busy), 1);
    while (!done && cyc < 300) begin
      if (disturb) begin
        in_valid = 1'b1;
        in_re = IN_W'($urandom); in_im = IN_W'($urandom);
      end
      @(negedge clk);
      cyc++;
    end
    // R4/R10: 8 row steps + 49 rotations + 8 column steps + start edge
    check(cyc == 66, "R4/R10", "cycles to done", cyc, 66);
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R5", $sformatf("out_valid beat %0d", n), int'(out_valid), 1);
      check(near(int'(out_re), rr[n]) && near(int'(out_im), ri[n]), tag,
            $sformatf("X[%0d] re/im=%0d/%0d", n, int'(out_im), $rtoi(ri[n])),
            int'(out_re), $rtoi(rr[n]));
      if (n == 63) begin
        start = 1'b0; in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R5", "out_valid after 64 beats", int'(out_valid), 0);
    check(busy == 1'b0, "R6", "busy after stream", int'(busy), 0);
    if (disturb) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R6", "no restart from start held while busy",
              int'(busy), 0);
      end
    end
  endtask

  task automatic rand_frame();
    for (int i = 0; i < 64; i++) begin
      xr[i] = int'($urandom_range(4094)) - 2047;
      xi[i] = int'($urandom_range(4094)) - 2047;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R4 watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0640));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    check(busy == 1'b0, "R8", "busy after reset", int'(busy), 0);
    check(done == 1'b0, "R8", "done after reset", int'(done), 0);
    check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);

    // R1: impulse at n=0 gives flat spectrum
    for (int i = 0; i < 64; i++) begin xr[i] = 0; xi[i] = 0; end
    xr[0] = 1000;
    load_frame(); run_frame(1'b0, 1'b0, 1'b0, "R1");

    // R2: shifted impulse, inverse direction
    for (int i = 0; i < 64; i++) begin xr[i] = 0; xi[i] = 0; end
    xr[5] = 500; xi[5] = -300;
    load_frame(); run_frame(1'b1, 1'b0, 1'b0, "R2");

    // R9: full-scale DC, extreme negative imaginary
    for (int i = 0; i < 64; i++) begin xr[i] = 2047; xi[i] = -2048; end
    load_frame(); run_frame(1'b0, 1'b0, 1'b0, "R9");

    // R9: alternating full scale lands in bin 32
    for (int i = 0; i < 64; i++) begin xr[i] = (i % 2) ? -2048 : 2047; xi[i] = 0; end
    load_frame(); run_frame(1'b1, 1'b0, 1'b0, "R9");

    // R1 / R2: random frames in both directions
    for (int f = 0; f < 3; f++) begin rand_frame(); load_frame(); run_frame(1'b0, 1'b0, 1'b0, "R1"); end
    for (int f = 0; f < 3; f++) begin rand_frame(); load_frame(); run_frame(1'b1, 1'b0, 1'b0, "R2"); end

    // R3: direction flipped after start must not matter
    rand_frame(); load_frame(); run_frame(1'b1, 1'b1, 1'b0, "R3");
    rand_frame(); load_frame(); run_frame(1'b0, 1'b1, 1'b0, "R3");

    // R7: start and in_valid driven throughout busy; result must be of loaded frame
    rand_frame(); load_frame(); run_frame(1'b0, 1'b0, 1'b1, "R7");
    // R7: next frame loads from position 0 despite ignored writes
    rand_frame(); load_frame(); run_frame(1'b1, 1'b0, 1'b0, "R7");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule